// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides, cycle by cycle, whether the processor core must leave its current instruction stream and enter an exception handler. It watches two level-sensitive hardware request lines (a fast one and a normal one), a one-cycle software trap strobe produced by the instruction decoder, the live status word and the address of the next instruction. Masking follows the two interrupt-disable bits of the status word. The fast line beats the normal line, and both beat the trap.

When an entry is chosen the block raises `take_o` for exactly one cycle. In that same cycle it presents the handler vector for the PC, the new processor mode, the return address for the link register of that mode, the status word to save into that mode's saved-status register, and the rewritten status word. The core loads these values and flushes its pipeline on the pulse. The cycle that follows a pulse is a flush cycle. No new entry is chosen in that cycle, so the core has time to feed the rewritten status back. A trap that loses arbitration, or that arrives during a flush cycle, is held and taken at the first later cycle where it wins.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `take_o` is 0 and every other output is 0.
- R2: If `fast_req_i` is high and status bit 6 (fast mask) is 0 in a cycle where an entry may be chosen, `take_o` is high in the next cycle with vector 0x0000_001C and mode 5'b10001.
- R3: If `norm_req_i` is high, status bit 7 (normal mask) is 0 and no fast entry wins, the next cycle takes an entry with vector 0x0000_0018 and mode 5'b10010.
- R4: A trap that wins arbitration gives an entry in the next cycle with vector 0x0000_0008 and mode 5'b10011.
- R5: When both hardware lines are unmasked in the same cycle, the fast entry is taken.
- R6: A normal request is ignored while status bit 7 is 1, and a fast request is ignored while status bit 6 is 1. A masked request causes no take and leaves every output unchanged.
- R7: A trap that coincides with an unmasked hardware request, or that arrives in a flush cycle, is kept pending. It is taken at the first later cycle with no unmasked hardware request that is not a flush cycle.
- R8: On entry `saved_stat_o` equals the status word sampled in the deciding cycle, and `ret_addr_o` equals the next-instruction address sampled in that cycle.
- R9: On entry `new_stat_o` is the sampled status with bits [4:0] replaced by the target mode, bit 7 set, bit 6 set only for a fast entry (otherwise copied), bits 5 and 24 (instruction-state bits) cleared and all other bits copied.
- R10: `take_o` never stays high for two consecutive cycles.
- R11: In a cycle where `take_o` is low, all other outputs keep the values they had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_req_i | input | 1 | Fast hardware request, level-sensitive |
| norm_req_i | input | 1 | Normal hardware request, level-sensitive |
| sw_trap_i | input | 1 | Decoded software trap strobe |
| cur_stat_i | input | 32 | Current status word |
| next_pc_i | input | 32 | Address of the next instruction |
| take_o | output | 1 | One-cycle entry pulse |
| tgt_mode_o | output | 5 | Mode entered |
| vec_addr_o | output | 32 | Handler vector for the PC |
| ret_addr_o | output | 32 | Value for the link register of the target mode |
| saved_stat_o | output | 32 | Value for the saved-status register of the target mode |
| new_stat_o | output | 32 | Rewritten current status word |

## Verification
Every result of this block is due one clock after the inputs that cause it. The requests, trap, status and next address are sampled at one rising edge, and the pulse and all entry values appear at that edge's output. A held trap adds its own wait, and the bench model counts that wait by tracking the pending flag and the flush cycle itself. The bench changes inputs on the falling edge. At the next falling edge it compares every output with the prediction made from the inputs it drove one edge earlier. It checks the held values on every cycle without a pulse.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_FAST = 2'd1,
      SRC_NORM = 2'd2,
      SRC_TRAP = 2'd3
   } exc_src_e;

   // status word field positions
   localparam int MODE_LSB  = 0;
   localparam int TSTATE_BIT = 5;
   localparam int FMASK_BIT = 6;
   localparam int NMASK_BIT = 7;
   localparam int JSTATE_BIT = 24;

   // target modes
   localparam logic [4:0] MODE_FAST = 5'b10001;
   localparam logic [4:0] MODE_NORM = 5'b10010;
   localparam logic [4:0] MODE_SVC  = 5'b10011;

   // vector offsets
   localparam logic [7:0] OFS_TRAP = 8'h08;
   localparam logic [7:0] OFS_NORM = 8'h18;
   localparam logic [7:0] OFS_FAST = 8'h1C;

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
   import exc_entry_pkg::*;
#(
   parameter int STAT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_req_i,
   input  logic              norm_req_i,
   input  logic              sw_trap_i,
   input  logic              flush_i,
   input  logic [STAT_W-1:0] stat_i,
   output exc_src_e          src_o
);

   logic fast_ok, norm_ok, trap_ok;
   logic trap_hold_q, trap_hold_d;

   assign fast_ok = fast_req_i & ~stat_i[FMASK_BIT];
   assign norm_ok = norm_req_i & ~stat_i[NMASK_BIT];
   assign trap_ok = sw_trap_i | trap_hold_q;

   always_comb begin
      src_o = SRC_NONE;
      if (!flush_i) begin
         if (fast_ok)      src_o = SRC_FAST;
         else if (norm_ok) src_o = SRC_NORM;
         else if (trap_ok) src_o = SRC_TRAP;
      end
   end

   assign trap_hold_d = trap_ok & (src_o != SRC_TRAP);

   always_ff @(posedge clk) begin
      if (!rst_n) trap_hold_q <= 1'b0;
      else        trap_hold_q <= trap_hold_d;
   end

   // R5
   fast_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_ok && norm_ok && !flush_i) |-> (src_o == SRC_FAST));

   // R7
   trap_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_trap_i && src_o != SRC_TRAP) |=> trap_hold_q);

endmodule

// File: rtl/exc_stat_build.sv
module exc_stat_build
   import exc_entry_pkg::*;
#(
   parameter int STAT_W   = 32,
   parameter int ADDR_W   = 32,
   parameter int MODE_W   = 5,
   parameter bit HIGH_VEC = 1'b0
) (
   input  exc_src_e          src_i,
   input  logic [STAT_W-1:0] stat_i,
   output logic [MODE_W-1:0] mode_o,
   output logic [ADDR_W-1:0] vec_o,
   output logic [STAT_W-1:0] stat_o
);

   localparam int OFS_W = 8;
   logic [OFS_W-1:0]  ofs;
   logic [ADDR_W-1:0] base;

   always_comb begin
      unique case (src_i)
         SRC_FAST: begin mode_o = MODE_FAST; ofs = OFS_FAST; end
         SRC_NORM: begin mode_o = MODE_NORM; ofs = OFS_NORM; end
         SRC_TRAP: begin mode_o = MODE_SVC;  ofs = OFS_TRAP; end
         default:  begin mode_o = '0;        ofs = '0;       end
      endcase
   end

   generate
      if (HIGH_VEC) begin : g_high
         assign base = {{(ADDR_W-16){1'b1}}, 16'h0000};
      end else begin : g_low
         assign base = '0;
      end
   endgenerate

   assign vec_o = base | {{(ADDR_W-OFS_W){1'b0}}, ofs};

   always_comb begin
      stat_o = stat_i;
      stat_o[MODE_LSB +: MODE_W] = mode_o;
      stat_o[NMASK_BIT]  = 1'b1;
      if (src_i == SRC_FAST) stat_o[FMASK_BIT] = 1'b1;
      stat_o[TSTATE_BIT] = 1'b0;
      stat_o[JSTATE_BIT] = 1'b0;
   end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int STAT_W   = 32,
   parameter int ADDR_W   = 32,
   parameter int MODE_W   = 5,
   parameter bit HIGH_VEC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_req_i,
   input  logic              norm_req_i,
   input  logic              sw_trap_i,
   input  logic [STAT_W-1:0] cur_stat_i,
   input  logic [ADDR_W-1:0] next_pc_i,
   output logic              take_o,
   output logic [MODE_W-1:0] tgt_mode_o,
   output logic [ADDR_W-1:0] vec_addr_o,
   output logic [ADDR_W-1:0] ret_addr_o,
   output logic [STAT_W-1:0] saved_stat_o,
   output logic [STAT_W-1:0] new_stat_o
);

   generate
      if (STAT_W < JSTATE_BIT + 1) begin : g_bad_stat
         $error("STAT_W too narrow for the status fields");
      end
      if (ADDR_W < 16) begin : g_bad_addr
         $error("ADDR_W must be at least 16");
      end
      if (MODE_W != 5) begin : g_bad_mode
         $error("MODE_W must be 5");
      end
   endgenerate

   exc_src_e          src;
   logic [MODE_W-1:0] mode_d;
   logic [ADDR_W-1:0] vec_d;
   logic [STAT_W-1:0] stat_d;

   exc_prio_arb #(.STAT_W(STAT_W)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .fast_req_i (fast_req_i),
      .norm_req_i (norm_req_i),
      .sw_trap_i  (sw_trap_i),
      .flush_i    (take_o),
      .stat_i     (cur_stat_i),
      .src_o      (src)
   );

   exc_stat_build #(
      .STAT_W   (STAT_W),
      .ADDR_W   (ADDR_W),
      .MODE_W   (MODE_W),
      .HIGH_VEC (HIGH_VEC)
   ) u_build (
      .src_i  (src),
      .stat_i (cur_stat_i),
      .mode_o (mode_d),
      .vec_o  (vec_d),
      .stat_o (stat_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_o       <= 1'b0;
         tgt_mode_o   <= '0;
         vec_addr_o   <= '0;
         ret_addr_o   <= '0;
         saved_stat_o <= '0;
         new_stat_o   <= '0;
      end else begin
         take_o <= (src != SRC_NONE);
         if (src != SRC_NONE) begin
            tgt_mode_o   <= mode_d;
            vec_addr_o   <= vec_d;
            ret_addr_o   <= next_pc_i;
            saved_stat_o <= cur_stat_i;
            new_stat_o   <= stat_d;
         end
      end
   end

   // R10
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> !take_o);

   // R2
   fast_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_req_i && !cur_stat_i[FMASK_BIT] && !take_o) |=>
         (take_o && tgt_mode_o == MODE_FAST));

   // R8
   saved_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src != SRC_NONE) |=> (saved_stat_o == $past(cur_stat_i)));

   // R9
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (new_stat_o[NMASK_BIT] && !new_stat_o[TSTATE_BIT]));

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_NONE) |=> $stable(vec_addr_o) && $stable(new_stat_o));

endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fast_req = 1'b0, norm_req = 1'b0, trap = 1'b0;
   logic [31:0] stat = '0, npc = '0;
   logic        take;
   logic [4:0]  mode;
   logic [31:0] vec, ret, sav, nst;

   int total = 0, bad = 0;

   // model state
   bit          m_hold = 0, m_take = 0;
   bit          e_take = 0;
   logic [4:0]  e_mode = '0;
   logic [31:0] e_vec = '0, e_ret = '0, e_sav = '0, e_nst = '0;

   always #2 clk = ~clk;

   exc_entry_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .fast_req_i(fast_req), .norm_req_i(norm_req),
      .sw_trap_i(trap), .cur_stat_i(stat), .next_pc_i(npc),
      .take_o(take), .tgt_mode_o(mode), .vec_addr_o(vec), .ret_addr_o(ret),
      .saved_stat_o(sav), .new_stat_o(nst)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic compare_all(input string tk, input string fld);
      chk({tk, " take"}, {31'd0, take}, {31'd0, e_take});
      chk({fld, " mode"}, {27'd0, mode}, {27'd0, e_mode});
      chk({fld, " vector"}, vec, e_vec);
      chk({"R8", " ret"}, ret, e_ret);
      chk({"R8", " saved"}, sav, e_sav);
      chk({"R9", " status"}, nst, e_nst);
   endtask

   // one cycle: check outputs due now, drive new inputs, predict next outputs
   task automatic step(input bit f, input bit n, input bit t,
                       input logic [31:0] s, input logic [31:0] pc, input string tag);
      int src;
      logic [31:0] ns;
      @(negedge clk);
      if (e_take) compare_all("R10", tag);
      else        compare_all("R10", "R11");
      fast_req = f; norm_req = n; trap = t; stat = s; npc = pc;
      src = 0;
      if (!m_take) begin
         if (f && !s[6])          src = 1;
         else if (n && !s[7])     src = 2;
         else if (t || m_hold)    src = 3;
      end
      m_hold = (t || m_hold) && (src != 3);
      m_take = (src != 0);
      e_take = m_take;
      if (src != 0) begin
         ns = s;
         case (src)
            1: begin e_mode = 5'b10001; e_vec = 32'h1C; ns[6] = 1'b1; end
            2: begin e_mode = 5'b10010; e_vec = 32'h18; end
            default: begin e_mode = 5'b10011; e_vec = 32'h08; end
         endcase
         ns[4:0] = e_mode; ns[7] = 1'b1; ns[5] = 1'b0; ns[24] = 1'b0;
         e_ret = pc; e_sav = s; e_nst = ns;
      end
   endtask

   initial begin : watchdog
      #(200000 * 4);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      logic [31:0] lf;
      repeat (3) @(negedge clk);
      // R1 during reset
      compare_all("R1", "R1");
      rst_n = 1'b1;
      step(0, 0, 0, 32'h10, 32'h100, "R1");
      step(1, 0, 0, 32'h0000_0010, 32'h200, "R2");
      step(0, 0, 0, 32'h10, 32'h0, "R2");
      step(0, 1, 0, 32'h0000_0010, 32'h300, "R3");
      step(0, 0, 0, 32'h10, 32'h0, "R3");
      step(0, 0, 1, 32'h0000_00D0, 32'h400, "R4");
      step(0, 0, 0, 32'h10, 32'h0, "R4");
      step(1, 1, 0, 32'h0000_0010, 32'h500, "R5");
      step(0, 0, 0, 32'h10, 32'h0, "R5");
      step(0, 1, 0, 32'h0000_0090, 32'h600, "R6");
      step(1, 0, 0, 32'h0000_0050, 32'h604, "R6");
      step(1, 1, 0, 32'h0000_00D0, 32'h608, "R6");
      step(1, 1, 0, 32'h0000_0050, 32'h60C, "R6");
      step(0, 0, 0, 32'h10, 32'h0, "R6");
      step(0, 1, 1, 32'h0000_0010, 32'h700, "R7");
      step(0, 0, 0, 32'h10, 32'h704, "R7");
      step(0, 0, 0, 32'h10, 32'h708, "R7");
      step(0, 0, 0, 32'h10, 32'h70C, "R7");
      step(1, 0, 0, 32'h10, 32'h710, "R7");
      step(0, 0, 1, 32'h10, 32'h714, "R7");
      step(0, 0, 0, 32'h10, 32'h718, "R7");
      step(0, 0, 0, 32'h10, 32'h71C, "R7");
      step(1, 0, 0, 32'h0100_0020, 32'h800, "R9");
      step(0, 0, 0, 32'h10, 32'h0, "R9");
      step(0, 1, 0, 32'hF100_0033, 32'h900, "R9");
      step(1, 1, 1, 32'h10, 32'hA00, "R10");
      step(1, 1, 1, 32'h10, 32'hA04, "R10");
      step(0, 0, 0, 32'h10, 32'hA08, "R10");
      step(0, 0, 0, 32'h10, 32'hA0C, "R10");
      lf = 32'hACE1_1234;
      for (int i = 0; i < 400; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         step(lf[3], lf[7], lf[11] & lf[2], {lf[31:8], lf[15:8]} ^ {8'h0, lf[23:0]},
              lf ^ 32'h5A5A_0000, "R11");
      end
      step(0, 0, 0, 32'hC0, 32'h0, "R11");
      step(0, 0, 0, 32'hC0, 32'h0, "R11");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule